// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block sits on a simple APB-style register port and runs one successive-approximation conversion at a time for an analog front end with up to eight multiplexed inputs. Software programs a power-up settling delay, then writes the control register with the power bit set, a channel number and, optionally, an interrupt enable. Writing the power bit is what starts a conversion; there is no separate start bit. The block waits out the programmed delay, then resolves the result one bit per clock, most significant bit first. For each bit it drives a trial code to the external DAC and reads back the external comparator. At the end it latches the result, raises a sticky completion flag and, if enabled, the interrupt line.

A write of all zeros to the control register is the single clean-up action. It clears the completion flag, drops the interrupt, powers the converter down and, if a conversion is running, aborts it. Each new conversion needs a fresh write with the power bit set. The comparator, the DAC, the input multiplexer and any clock-domain crossing sit outside the block and appear only as ports. The register port and the converter share one clock.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `pwr_on` is 0, `irq` is 0 and `dac_code` is 0.
- R2: Byte offsets: result at 0x0, status at 0x4, control at 0x8, delay at 0xC. Control fields: bits [2:0] channel, bit 3 power, bit 5 interrupt enable, bit 6 completion flag. Status bit 0 is busy. Unused bits read 0.
- R3: A control write with bit 3 set while idle starts a conversion, and status busy reads 1 from the write's clock edge until the result is latched. A nonzero write with bit 3 clear updates the fields but starts nothing.
- R4: With delay D, the search begins D cycles after the start edge (at once when D is 0), so busy lasts D + RES cycles.
- R5: The search makes one comparator decision per cycle, MSB first. The trial code on `dac_code` is the bits already kept plus the bit under test. A bit is kept when `cmp_in` is 1. `dac_code` is 0 whenever no search is running. The result holds RES bits, and result-register bits above RES read 0.
- R6: The channel on `chan_sel` is taken when the conversion starts and held until it ends. A nonzero control write while busy changes nothing.
- R7: On completion the completion flag is set and stays set until a zero control write. `irq` is high exactly when the flag and the interrupt enable are both set.
- R8: A zero control write clears the flag, the enable, the channel and the power bit, and drives `irq` and `pwr_on` low.
- R9: A zero control write during a conversion ends it at that edge. Busy reads 0 afterwards, and the result register keeps its earlier value.
- R10: The delay register stores 6 bits. Higher written bits are dropped and read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the register port and the converter |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 4 | Register byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for `paddr` (combinational) |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | RES | Trial code for the DAC |
| chan_sel | output | CH_W | Input multiplexer select |
| pwr_on | output | 1 | Converter power enable |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is a zero write that lands in the middle of the bit search rather than in the delay phase or while idle. The aim is to show that the result register keeps the previous conversion's value and that no flag appears. The bench programs a delay of 8, starts a conversion and counts clock cycles until it is several decisions into the search, then issues the zero write. A following conversion on the same channel shows that a fresh power-up write is needed and is enough. The bench's comparator answers from a per-channel integer input, so a channel swap attempted mid-conversion would show up as a wrong trial-code sequence.

// File: rtl/sarc_pkg.sv
// Package: shared offsets, field positions and sequencer states for the
// SAR ADC controller. Assumes a 4-bit byte offset and a 32-bit data bus.
package sarc_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int DLY_W  = 6;

    localparam logic [ADDR_W-1:0] OFF_RESULT = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_DELAY  = 4'hC;

    localparam int CB_PWR  = 3;
    localparam int CB_IEN  = 5;
    localparam int CB_FLAG = 6;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_CONV = 2'd2
    } seq_state_t;
endpackage

// File: rtl/sarc_seq.sv
// Module: power-up delay counter and bit-serial successive-approximation
// engine. Assumes start is only pulsed while idle and abort has priority
// over everything. Produces one comparator decision per clock, MSB first.
module sarc_seq
    import sarc_pkg::*;
#(
    parameter int RES = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [DLY_W-1:0] dly,
    input  logic             cmp_in,
    output logic [RES-1:0]   dac_code,
    output logic             busy,
    output logic             done,
    output logic [RES-1:0]   result
);
    localparam int BIT_W = (RES > 1) ? $clog2(RES) : 1;
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(RES - 1);

    seq_state_t       st;
    logic [DLY_W-1:0] cnt;
    logic [BIT_W-1:0] idx;
    logic [RES-1:0]   acc;
    logic [RES-1:0]   trial;

    // Trial code: kept bits plus the bit under test.
    assign trial    = acc | (RES'(1) << idx);
    assign dac_code = (st == SEQ_CONV) ? trial : '0;
    assign busy     = (st != SEQ_IDLE);
    assign done     = (st == SEQ_CONV) && (idx == '0);
    // Value of the kept bits after this cycle's decision.
    assign result   = cmp_in ? trial : acc;

    // State, delay count and search registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
            idx <= '0;
            acc <= '0;
        end else if (abort) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                SEQ_IDLE: begin
                    if (start) begin
                        acc <= '0;
                        idx <= TOP_BIT;
                        cnt <= dly;
                        st  <= (dly == '0) ? SEQ_CONV : SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == DLY_W'(1)) st <= SEQ_CONV;
                end
                SEQ_CONV: begin
                    acc <= result;
                    if (idx == '0) st <= SEQ_IDLE;
                    else           idx <= idx - 1'b1;
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sarc_regs.sv
// Module: register file and bus decode. Writes land on a bus access phase
// (psel and penable and pwrite). Reads are combinational from paddr.
// Assumes the sequencer reports busy and a one-cycle done with its result.
module sarc_regs
    import sarc_pkg::*;
#(
    parameter int RES  = 10,
    parameter int CH_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              seq_busy,
    input  logic              seq_done,
    input  logic [RES-1:0]    seq_result,
    output logic              start,
    output logic              abort,
    output logic [DLY_W-1:0]  dly,
    output logic [CH_W-1:0]   chan,
    output logic              pwr,
    output logic              ien,
    output logic              flag,
    output logic [RES-1:0]    data_q
);
    logic wr, wr_ctrl, wr_dly;

    assign wr      = psel && penable && pwrite;
    assign wr_ctrl = wr && (paddr == OFF_CTRL);
    assign wr_dly  = wr && (paddr == OFF_DELAY);
    assign abort   = wr_ctrl && (pwdata == '0);
    assign start   = wr_ctrl && pwdata[CB_PWR] && !seq_busy;

    // Control fields: clear on zero write, load only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            chan <= '0;
            pwr  <= 1'b0;
            ien  <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (wr_ctrl && !seq_busy) begin
                chan <= pwdata[CH_W-1:0];
                pwr  <= pwdata[CB_PWR];
                ien  <= pwdata[CB_IEN];
            end
            if (seq_done) flag <= 1'b1;
        end
    end

    // Result register: loaded on completion unless aborted that edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                  data_q <= '0;
        else if (seq_done && !abort) data_q <= seq_result;
    end

    // Delay register: low six bits of the write.
    always_ff @(posedge clk) begin
        if (!rst_n)      dly <= '0;
        else if (wr_dly) dly <= pwdata[DLY_W-1:0];
    end

    // Read mux: unused bits are zero.
    always_comb begin
        prdata = '0;
        case (paddr)
            OFF_RESULT: prdata[RES-1:0] = data_q;
            OFF_STATUS: prdata[0]       = seq_busy;
            OFF_CTRL: begin
                prdata[CH_W-1:0] = chan;
                prdata[CB_PWR]   = pwr;
                prdata[CB_IEN]   = ien;
                prdata[CB_FLAG]  = flag;
            end
            OFF_DELAY:  prdata[DLY_W-1:0] = dly;
            default:    prdata = '0;
        endcase
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
// Module: top of the SAR ADC controller. Joins the register file to the
// conversion sequencer and forms the interrupt. Assumes one clock for
// bus and converter, and RES of 10 or 12 with NUM_CH up to 8.
module sar_adc_ctrl
    import sarc_pkg::*;
#(
    parameter int RES    = 10,
    parameter int NUM_CH = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              cmp_in,
    output logic [RES-1:0]    dac_code,
    output logic [CH_W-1:0]   chan_sel,
    output logic              pwr_on,
    output logic              irq
);
    logic             seq_start, seq_abort, seq_busy, seq_done;
    logic [RES-1:0]   seq_result, data_q;
    logic [DLY_W-1:0] dly_q;
    logic             ctl_ien, ctl_flag;

    sarc_regs #(.RES(RES), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .seq_busy(seq_busy), .seq_done(seq_done), .seq_result(seq_result),
        .start(seq_start), .abort(seq_abort), .dly(dly_q),
        .chan(chan_sel), .pwr(pwr_on), .ien(ctl_ien), .flag(ctl_flag),
        .data_q(data_q)
    );

    sarc_seq #(.RES(RES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(seq_start), .abort(seq_abort), .dly(dly_q),
        .cmp_in(cmp_in), .dac_code(dac_code),
        .busy(seq_busy), .done(seq_done), .result(seq_result)
    );

    // Interrupt: flag gated by enable (R7).
    assign irq = ctl_flag & ctl_ien;
endmodule

// File: rtl/sarc_chk.sv
// Module: property checker for the SAR ADC controller, attached by bind.
// Watches bus ports, outputs and the busy, flag, enable and result state.
module sarc_chk
    import sarc_pkg::*;
#(
    parameter int RES  = 10,
    parameter int CH_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic              irq,
    input logic              pwr_on,
    input logic [RES-1:0]    dac_code,
    input logic [CH_W-1:0]   chan_sel,
    input logic              busy,
    input logic              flag,
    input logic              ien,
    input logic [RES-1:0]    data_q
);
    logic zw;
    assign zw = psel && penable && pwrite && (paddr == OFF_CTRL) && (pwdata == '0);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!irq && !pwr_on)); // R1
    AST_DAC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (dac_code == '0)); // R5
    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(chan_sel)); // R6
    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) ($fell(busy) && !$past(zw)) |-> flag); // R7
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ien); // R7
    AST_ZERO_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) $past(zw) |-> (!busy && !flag && !pwr_on && !irq)); // R8
    AST_RESULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n) ($stable(data_q) || ($fell(busy) && !$past(zw)))); // R9
endmodule

bind sar_adc_ctrl sarc_chk #(.RES(RES), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata),
    .irq(irq), .pwr_on(pwr_on), .dac_code(dac_code), .chan_sel(chan_sel),
    .busy(seq_busy), .flag(ctl_flag), .ien(ctl_ien), .data_q(data_q)
);

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;
    localparam int RES = 10;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        cmp_in;
    logic [RES-1:0] dac_code;
    logic [2:0]  chan_sel;
    logic        pwr_on, irq;

    int vin [8];
    int total = 0, bad = 0, cyc = 0;
    bit finished = 0, seen_edge = 0;

    // reference model state
    int m_bit = -1, m_wait = 0, m_acc = 0, m_data = 0, m_flag = 0, m_ien = 0;
    int m_pwr = 0, m_chan = 0, m_dly = 0;

    always #10 clk = ~clk;

    assign cmp_in = (vin[chan_sel] >= int'(dac_code));

    sar_adc_ctrl #(.RES(RES), .NUM_CH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cmp_in(cmp_in),
        .dac_code(dac_code), .chan_sel(chan_sel), .pwr_on(pwr_on), .irq(irq)
    );

    task automatic check(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    function automatic int m_trial();
        return m_acc | (1 << m_bit);
    endfunction

    function automatic int m_read(int a);
        case (a)
            0: return m_data;
            4: return (m_bit >= 0) ? 1 : 0;
            8: return m_chan | (m_pwr << 3) | (m_ien << 5) | (m_flag << 6);
            12: return m_dly;
            default: return 0;
        endcase
    endfunction

    // Behavioural model, advanced on each rising edge.
    always @(posedge clk) begin
        int d;
        bit wr, was_busy;
        d = int'(pwdata);
        wr = psel && penable && pwrite;
        was_busy = (m_bit >= 0);
        seen_edge = 1;
        if (!rst_n) begin
            m_bit = -1; m_wait = 0; m_acc = 0; m_data = 0; m_flag = 0;
            m_ien = 0; m_pwr = 0; m_chan = 0; m_dly = 0;
        end else if (wr && paddr == 8 && d == 0) begin
            m_bit = -1; m_wait = 0; m_flag = 0; m_pwr = 0; m_ien = 0; m_chan = 0;
        end else begin
            if (was_busy) begin
                if (m_wait > 0) m_wait--;
                else begin
                    if (vin[m_chan] >= m_trial()) m_acc = m_trial();
                    if (m_bit == 0) begin
                        m_data = m_acc; m_flag = 1; m_bit = -1;
                    end else m_bit--;
                end
            end
            if (wr && paddr == 8 && !was_busy) begin
                m_chan = d & 7; m_ien = (d >> 5) & 1; m_pwr = (d >> 3) & 1;
                if (m_pwr == 1) begin
                    m_bit = RES - 1; m_acc = 0; m_wait = m_dly;
                end
            end
            if (wr && paddr == 12) m_dly = d & 63;
        end
    end

    // Per-cycle comparison of outputs with the model.
    always @(negedge clk) begin
        if (seen_edge && rst_n && !finished) begin
            check("R5 dac_code", int'(dac_code),
                  (m_bit >= 0 && m_wait == 0) ? m_trial() : 0);
            check("R6 chan_sel", int'(chan_sel), m_chan);
            check("R7 irq", int'(irq), m_flag & m_ien);
            check("R8 pwr_on", int'(pwr_on), m_pwr);
        end
    end

    task automatic bus_write(int a, int d);
        @(negedge clk);
        psel = 1; pwrite = 1; penable = 0; paddr = 4'(a); pwdata = 32'(d);
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_read(int a, output int v);
        @(negedge clk);
        paddr = 4'(a);
        #1;
        v = int'(prdata);
        check("R2 read vs model", v, m_read(a));
    endtask

    task automatic wait_idle(output int n);
        int v;
        n = 0;
        for (int k = 0; k < 200; k++) begin
            bus_read(4, v);
            if (v == 0) break;
            n++;
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_LIMIT && !finished) begin
            bad++; total++;
            $display("FAIL R3 watchdog: cycles=%0d expected < %0d", cyc, WD_LIMIT);
            finish_run();
        end
    end

    initial begin
        int v, n;
        for (int i = 0; i < 8; i++) vin[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        for (int a = 0; a < 16; a += 4) begin
            bus_read(a, v);
            check("R1 register after reset", v, 0);
        end
        check("R1 irq after reset", int'(irq), 0);
        check("R1 pwr_on after reset", int'(pwr_on), 0);

        // R10: delay width
        bus_write(12, 32'hFF);
        bus_read(12, v);
        check("R10 delay truncated", v, 32'h3F);
        bus_write(12, 8);

        // R3: nonzero write without power bit starts nothing
        bus_write(8, 32'h21);
        repeat (3) @(negedge clk);
        bus_read(4, v);
        check("R3 no start without power", v, 0);
        bus_read(8, v);
        check("R3 fields loaded", v, 32'h21);

        // R5 / R7: full conversion on channel 0 with interrupt
        vin[0] = 32'h2A5;
        bus_write(8, 32'h28);
        bus_read(4, v);
        check("R3 busy after start", v, 1);
        wait_idle(n);
        bus_read(0, v);
        check("R5 result channel 0", v, 32'h2A5);
        bus_read(8, v);
        check("R2 control after done", v, 32'h68);
        check("R7 irq raised", int'(irq), 1);

        // R8: zero write clears
        bus_write(8, 0);
        check("R8 irq cleared", int'(irq), 0);
        check("R8 power off", int'(pwr_on), 0);
        bus_read(8, v);
        check("R8 control cleared", v, 0);
        bus_read(0, v);
        check("R8 result kept", v, 32'h2A5);

        // R6: channel held, busy writes ignored; R7 gate off
        vin[5] = 32'h3FF; vin[3] = 32'h011;
        bus_write(8, 32'h0D);
        repeat (2) @(negedge clk);
        bus_write(8, 32'h2B);
        check("R6 chan kept during busy", int'(chan_sel), 5);
        wait_idle(n);
        bus_read(0, v);
        check("R6 result from held channel", v, 32'h3FF);
        bus_read(8, v);
        check("R6 control unchanged by busy write", v, 32'h4D);
        check("R7 irq gated by enable", int'(irq), 0);

        // R4: delay 5, busy window (first busy negedge is not polled)
        bus_write(8, 0);
        bus_write(12, 5);
        vin[7] = 0;
        bus_write(8, 32'h0F);
        wait_idle(n);
        check("R4 busy length delay 5", n, 5 + RES - 1);
        bus_read(0, v);
        check("R5 result zero input", v, 0);

        // R4: delay 0
        bus_write(8, 0);
        bus_write(12, 0);
        vin[2] = 32'h155;
        bus_write(8, 32'h0A);
        wait_idle(n);
        check("R4 busy length delay 0", n, RES - 1);
        bus_read(0, v);
        check("R5 result channel 2", v, 32'h155);

        // R9: abort in the middle of the search
        bus_write(8, 0);
        bus_write(12, 8);
        vin[4] = 32'h0F0;
        bus_write(8, 32'h2C);
        repeat (12) @(negedge clk);
        bus_write(8, 0);
        bus_read(4, v);
        check("R9 busy cleared by abort", v, 0);
        bus_read(0, v);
        check("R9 result kept after abort", v, 32'h155);
        repeat (20) @(negedge clk);
        check("R9 no irq after abort", int'(irq), 0);
        bus_read(8, v);
        check("R9 no flag after abort", v, 0);

        // R3: a new power-up write is needed and is enough
        bus_write(8, 32'h2C);
        wait_idle(n);
        bus_read(0, v);
        check("R3 conversion after abort", v, 32'h0F0);
        check("R7 irq after restart", int'(irq), 1);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule